// File: doc/BRIEF.md
# Recirculating Slot-Aligned Tap Selector

This block feeds the M tap words of a time-folded processing element from a single input stream. The input word changes only once every P clock cycles, at the start of a sample period (slot 0). The usual way to serve such an element is a long delay line with one periodic P-to-1 multiplexer per tap. This block produces the same tap words every cycle with one 2-to-1 multiplexer and a ring of P*M-1 registers. In slot 0 the multiplexer loads the new input word into the ring. In the other P-1 slots it feeds back the word at the far end of the ring, so every stored word goes round the ring P times before it is dropped.

The slot counter is internal. It resets to 0, steps once per cycle and wraps after P-1. It is brought out so that the producer can align its word changes to slot 0. Tap j is read after j*P-1 ring registers, counted from the multiplexer output. The loop output is the last ring register, which is the value fed back.

Top module: `recirc_tap_selector`

## Requirements
- R1: `slot_o` is 0 during and straight after reset. It then increases by one each clock cycle and returns to 0 after P-1.
- R2: While `rst_ni` is low, every tap word and the loop output are zero.
- R3: In a cycle with `slot_o` = 0, the value on `x_i` enters the first ring register at the next clock edge.
- R4: In a cycle with `slot_o` ≠ 0, the first ring register takes the current loop output at the next clock edge.
- R5: Take an input that changes only in slot 0, and let x(n-t) be the input word t cycles back, with zero before reset release. In every cycle with slot number i, tap j (j = 1..M, tap j in bits (j-1)*W upward of `tap_o`) equals x(n-((P-1-i)*M + j-1)*P).
- R6: In every cycle with slot number 0, `loop_o` equals x(n-(P*M-1)*P).
- R7: Values driven on `x_i` in slots 1..P-1 have no effect on any tap word or on the loop output. The results of R5 and R6 hold with x taken as the slot-0 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | W | Input word, sampled in slot 0 |
| slot_o | output | max(1,clog2(P)) | Current slot number within the sample period |
| tap_o | output | M*W | Tap words, tap j in bits (j-1)*W upward |
| loop_o | output | W | Ring output, the value fed back |

## Verification
A wrong multiplexer select or a slot counter that drifts corrupts the ring contents. The first visible sign is tap 1 in slot P-1, since that tap reads the word loaded P-1 cycles earlier; the error then spreads to the higher taps in steps of P cycles. A ring register that is skipped or doubled shifts every tap beyond that register out of its slot. The bench therefore compares all taps in every cycle against a full delay-line model, with random words, fixed bit patterns and junk driven on the input outside slot 0.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  function automatic int slot_width(input int p);
    return (p > 1) ? $clog2(p) : 1;
  endfunction

  // registers between mux output and tap j
  function automatic int tap_depth(input int j, input int p);
    return j * p - 1;
  endfunction

endpackage

// File: rtl/tsel_slot_counter.sv
module tsel_slot_counter #(
  parameter int P      = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic              first_o
);

  localparam logic [SLOT_W-1:0] LastSlot = SLOT_W'(P - 1);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               slot_q <= '0;
    else if (slot_q == LastSlot) slot_q <= '0;
    else                       slot_q <= slot_q + 1'b1;
  end

  assign slot_o  = slot_q;
  assign first_o = (slot_q == '0);

endmodule

// File: rtl/tsel_loop_mux.sv
module tsel_loop_mux #(
  parameter int W = 16
) (
  input  logic         load_i,
  input  logic [W-1:0] new_i,
  input  logic [W-1:0] back_i,
  output logic [W-1:0] d_o
);

  always_comb begin
    if (load_i) d_o = new_i;
    else        d_o = back_i;
  end

endmodule

// File: rtl/tsel_shift_chain.sv
module tsel_shift_chain #(
  parameter int W = 16,
  parameter int L = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   d_i,
  output logic [L*W-1:0] chain_o
);

  logic [W-1:0] stage_q [L];

  for (genvar k = 0; k < L; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[k] <= '0;
        else         stage_q[k] <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[k] <= '0;
        else         stage_q[k] <= stage_q[k-1];
      end
    end
    assign chain_o[k*W +: W] = stage_q[k];
  end

endmodule

// File: rtl/recirc_tap_selector.sv
module recirc_tap_selector
  import tsel_pkg::*;
#(
  parameter int W = 16,
  parameter int P = 4,
  parameter int M = 3,
  localparam int SLOT_W = slot_width(P)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      x_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [M*W-1:0]    tap_o,
  output logic [W-1:0]      loop_o
);

  localparam int L = P * M - 1;

  logic              load_new;
  logic [W-1:0]      ring_d;
  logic [L*W-1:0]    chain_q;
  logic [W-1:0]      chain_head;

  tsel_slot_counter #(.P(P), .SLOT_W(SLOT_W)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_o  (slot_o),
    .first_o (load_new)
  );

  tsel_loop_mux #(.W(W)) u_mux (
    .load_i (load_new),
    .new_i  (x_i),
    .back_i (loop_o),
    .d_o    (ring_d)
  );

  tsel_shift_chain #(.W(W), .L(L)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (ring_d),
    .chain_o (chain_q)
  );

  assign chain_head = chain_q[W-1:0];
  assign loop_o     = chain_q[(L-1)*W +: W];

  for (genvar j = 1; j <= M; j++) begin : g_tap
    localparam int Depth = tap_depth(j, P);
    assign tap_o[(j-1)*W +: W] = chain_q[(Depth-1)*W +: W];
  end

endmodule

// File: rtl/tsel_checker.sv
module tsel_checker #(
  parameter int W      = 16,
  parameter int P      = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [W-1:0]      x_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic [W-1:0]      loop_i,
  input logic [W-1:0]      head_i
);

  localparam logic [SLOT_W-1:0] LastSlot = SLOT_W'(P - 1);

  assert_slot_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (slot_i == (($past(slot_i) == LastSlot) ? '0 : $past(slot_i) + 1'b1)));

  assert_reset_zero_R2: assert property (@(posedge clk_i)
    !rst_ni |-> (loop_i == '0 && head_i == '0 && slot_i == '0));

  assert_slot0_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == '0) |=> (head_i == $past(x_i)));

  assert_recirculate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i != '0) |=> (head_i == $past(loop_i)));

endmodule

bind recirc_tap_selector tsel_checker #(.W(W), .P(P), .SLOT_W(SLOT_W)) u_tsel_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .x_i    (x_i),
  .slot_i (slot_o),
  .loop_i (loop_o),
  .head_i (chain_head)
);

// File: tb/recirc_tap_selector_test.sv
`timescale 1ns/1ps
module recirc_tap_selector_test;

  localparam int W      = 16;
  localparam int P      = 4;
  localparam int M      = 3;
  localparam int SLOT_W = (P > 1) ? $clog2(P) : 1;
  localparam int HL     = (P * M - 1) * P + 1;
  localparam int WARM   = P * M * P;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [M*W-1:0]    taps;
    logic [W-1:0]      loopv;
    logic              junk;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic [W-1:0]      x_i = '0;
  logic [SLOT_W-1:0] slot_o;
  logic [M*W-1:0]    tap_o;
  logic [W-1:0]      loop_o;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  logic [W-1:0] held = '0;
  logic [W-1:0] hist [HL];
  exp_t q [$];

  always #10 clk_i = ~clk_i;

  recirc_tap_selector #(.W(W), .P(P), .M(M)) uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .slot_o (slot_o),
    .tap_o  (tap_o),
    .loop_o (loop_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // driver: one cycle, mode 0 random, 1 pattern, 2 random with junk off slot 0
  task automatic step(input int mode);
    exp_t e;
    int i;
    @(negedge clk_i);
    i = cyc % P;
    if (i == 0) begin
      if (mode == 1) held = ((cyc / P) % 2 == 0) ? {W{1'b1}} : {(W/2){2'b10}};
      else           held = W'($urandom());
    end
    x_i = (i != 0 && mode == 2) ? W'($urandom()) : held;
    for (int k = HL - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = held;
    e.slot  = SLOT_W'(i);
    e.junk  = (mode == 2);
    for (int j = 1; j <= M; j++)
      e.taps[(j-1)*W +: W] = hist[((P - 1 - i) * M + (j - 1)) * P];
    e.loopv = hist[(P * M - 1) * P];
    if (cyc >= WARM) q.push_back(e);
    cyc++;
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      #5;
      while (q.size() > 0) begin
        e = q.pop_front();
        check("R1 slot", W'(slot_o), W'(e.slot));
        for (int j = 1; j <= M; j++)
          check(e.junk ? "R7 tap" : "R5 tap", tap_o[(j-1)*W +: W], e.taps[(j-1)*W +: W]);
        if (e.slot == '0)
          check(e.junk ? "R7 loop" : "R6 loop", loop_o, e.loopv);
      end
    end
  end

  initial begin
    for (int k = 0; k < HL; k++) hist[k] = '0;
    #1 rst_ni = 1'b0;
    x_i = 16'hbeef;
    repeat (3) @(negedge clk_i);
    #5;
    check("R2 loop in reset", loop_o, '0);
    for (int j = 1; j <= M; j++) check("R2 tap in reset", tap_o[(j-1)*W +: W], '0);
    check("R1 slot in reset", W'(slot_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    x_i    = '0;
    held   = '0;
    cyc    = 1;
    #5;
    check("R1 slot after release", W'(slot_o), '0);
    repeat (300) step(0);
    repeat (100) step(1);
    repeat (300) step(2);
    repeat (60)  step(0);
    repeat (2) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule